// File: doc/BRIEF.md
# External Bus Read Cycle Sequencer

This block generates read cycles on a multiplexed address/data bus of a microcontroller. It runs on a clock whose period is one oscillator period. It drives a free-running bus clock at half that rate, an address-latch strobe, an active-low read strobe, and the address together with its output enable. On the returning data it captures one word per cycle.

The core side raises `req` with an address. The sequencer starts a cycle on the next tick if it is idle, or straight after the current cycle if that cycle is ending. It returns the captured word with a one-tick `ack`.

The cycle can be stretched in two ways, which add together. A 3-bit programmed wait count is sampled when the cycle starts. The `forceWait` mode bit adds one more wait state to every cycle. Setting `forceWait` to 0 gives the standard timing.

Top module: `extbus_seq`

## Requirements
- R1: A synchronous active-high reset returns the block to idle: `ale` is 0, `rdN` is 1, `adOe` is 0 and `ack` is 0 on the tick after reset.
- R2: While idle and `req` is 0, `ale` stays 0, `rdN` stays 1 and `adOe` stays 0.
- R3: `ale` is 1 for exactly one tick, and that tick is the first tick of each cycle. The cycle starts on the tick after the edge that sees `req` high while the block is idle or in the last tick of a cycle.
- R4: `adOe` is 1 on the first two ticks of a cycle, the `ale` tick and the tick after it. During those ticks `adOut` carries `addrIn` as sampled at the cycle start. From the third tick on, `adOe` is 0.
- R5: `rdN` goes to 0 on the third tick of a cycle. It stays 0 for 2 + 2·W ticks, where W is the total wait count of that cycle.
- R6: The programmed wait count `waitIn` is sampled only at the cycle start, and each wait state adds two ticks. A zero-wait cycle is 4 ticks from one `ale` rise to the next. Changing `waitIn` during a cycle has no effect on that cycle.
- R7: When `forceWait` is 1 at the cycle start, W = `waitIn` + 1. With `waitIn` = 7 this gives 8 wait states and a cycle of 20 ticks. When `forceWait` is 0, W = `waitIn`.
- R8: Read data on `busDataIn` is captured at the edge where `rdN` returns to 1. `ack` is 1 for exactly that one tick, and `rdData` holds the captured word.
- R9: If `req` is high during the last tick of a cycle, the next cycle's `ale` tick directly follows that tick, with no idle tick between them.
- R10: `clkOut` toggles on every tick after reset, so it has a period of two ticks and a high phase of one tick. It is 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock, one tick per oscillator period |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Read request from the core side |
| addrIn | input | AddrW | Address to read |
| waitIn | input | WaitW | Programmed wait-state count |
| forceWait | input | 1 | 1 adds one automatic wait state to every cycle |
| busDataIn | input | DataW | Data returned on the bus |
| ack | output | 1 | One-tick pulse when `rdData` is valid |
| rdData | output | DataW | Captured read word |
| clkOut | output | 1 | Bus clock at half the tick rate |
| ale | output | 1 | Address-latch strobe |
| rdN | output | 1 | Active-low read strobe |
| adOut | output | AddrW | Address driven onto the bus |
| adOe | output | 1 | Output enable for `adOut` |

## Verification
The bound checker watches the strobe relationships on every tick. It checks that `ale` lasts a single tick, that the address enable and the read strobe are never active together, and that the read strobe falls one tick after `ale` falls. It also checks that `ack` coincides exactly with the rise of `rdN`, that `clkOut` toggles every tick, and the idle state after reset.

The cycle length can only be shown by the bench's scenarios. This includes the two-tick cost of each programmed wait state, the extra forced wait up to the 20-tick maximum, and the fact that a change of `waitIn` in mid-cycle is ignored. The same holds for gapless back-to-back cycles and for the captured data values. A behavioural queue model predicts every tick of these scenarios.

// File: rtl/extbus_pkg.sv
package extbus_pkg;
  // Strobes passed from the control to the datapath
  typedef struct packed {
    logic load;     // cycle starts at this edge: latch the address
    logic capture;  // last tick of the cycle: latch the data, pulse ack
    logic ale;
    logic addrEn;
    logic rdLow;
  } busStrobes_t;
endpackage

// File: rtl/extbus_ctrl.sv
module extbus_ctrl
  import extbus_pkg::*;
#(
  parameter int WaitW = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [WaitW-1:0] waitIn,
  input  logic             forceWait,
  output busStrobes_t      strobes
);
  localparam int TotW   = WaitW + 1;
  localparam int MaxLen = 4 + (1 << (WaitW + 1));
  localparam int CntW   = $clog2(MaxLen);

  logic            busy;
  logic [CntW-1:0] tickCnt;
  logic [TotW-1:0] waitTot;
  logic [TotW-1:0] newWait;
  logic [CntW-1:0] lastIdx;
  logic            lastTick;
  logic            startCycle;

  // Total wait states of the cycle that is about to start
  assign newWait    = TotW'(waitIn) + TotW'(forceWait);
  // Index of the last tick of the running cycle: 4 + 2*W ticks in all
  assign lastIdx    = CntW'(3) + CntW'({waitTot, 1'b0});
  assign lastTick   = busy && (tickCnt == lastIdx);
  assign startCycle = req && (!busy || lastTick);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      tickCnt <= '0;
      waitTot <= '0;
    end else if (startCycle) begin
      busy    <= 1'b1;
      tickCnt <= '0;
      waitTot <= newWait;
    end else if (lastTick) begin
      busy    <= 1'b0;
    end else if (busy) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.load    = startCycle;
    strobes.capture = lastTick;
    strobes.ale     = busy && (tickCnt == '0);
    strobes.addrEn  = busy && (tickCnt < CntW'(2));
    strobes.rdLow   = busy && (tickCnt >= CntW'(2));
  end
endmodule

// File: rtl/extbus_dp.sv
module extbus_dp
  import extbus_pkg::*;
#(
  parameter int AddrW = 16,
  parameter int DataW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  busStrobes_t      strobes,
  input  logic [AddrW-1:0] addrIn,
  input  logic [DataW-1:0] busDataIn,
  output logic             ack,
  output logic [DataW-1:0] rdData,
  output logic             clkOut,
  output logic             ale,
  output logic             rdN,
  output logic [AddrW-1:0] adOut,
  output logic             adOe
);
  logic [AddrW-1:0] addrQ;
  logic [DataW-1:0] dataQ;
  logic             ackQ;
  logic             clkQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      addrQ <= '0;
      dataQ <= '0;
      ackQ  <= 1'b0;
      clkQ  <= 1'b0;
    end else begin
      clkQ <= !clkQ;
      ackQ <= strobes.capture;
      if (strobes.load)    addrQ <= addrIn;
      if (strobes.capture) dataQ <= busDataIn;
    end
  end

  assign ack    = ackQ;
  assign rdData = dataQ;
  assign clkOut = clkQ;
  assign ale    = strobes.ale;
  assign rdN    = !strobes.rdLow;
  assign adOut  = addrQ;
  assign adOe   = strobes.addrEn;
endmodule

// File: rtl/extbus_seq.sv
module extbus_seq
  import extbus_pkg::*;
#(
  parameter int AddrW = 16,
  parameter int DataW = 16,
  parameter int WaitW = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [AddrW-1:0] addrIn,
  input  logic [WaitW-1:0] waitIn,
  input  logic             forceWait,
  input  logic [DataW-1:0] busDataIn,
  output logic             ack,
  output logic [DataW-1:0] rdData,
  output logic             clkOut,
  output logic             ale,
  output logic             rdN,
  output logic [AddrW-1:0] adOut,
  output logic             adOe
);
  busStrobes_t strobes;

  extbus_ctrl #(.WaitW(WaitW)) u_ctrl (
    .clk(clk), .rst(rst), .req(req), .waitIn(waitIn),
    .forceWait(forceWait), .strobes(strobes)
  );

  extbus_dp #(.AddrW(AddrW), .DataW(DataW)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .addrIn(addrIn),
    .busDataIn(busDataIn), .ack(ack), .rdData(rdData), .clkOut(clkOut),
    .ale(ale), .rdN(rdN), .adOut(adOut), .adOe(adOe)
  );
endmodule

// File: rtl/extbus_seq_chk.sv
module extbus_seq_chk (
  input logic clk,
  input logic rst,
  input logic ack,
  input logic clkOut,
  input logic ale,
  input logic rdN,
  input logic adOe
);
  // Set once a full tick has passed since reset, so $past never sees pre-reset values
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!ale && rdN && !adOe && !ack));

  a_r3_ale_one_tick: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);

  a_r4_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(adOe && !rdN));

  a_r4_addr_with_ale: assert property (@(posedge clk) disable iff (rst)
    ale |-> adOe);

  a_r5_rd_after_ale: assert property (@(posedge clk) disable iff (rst || !armed)
    $fell(ale) |=> (!rdN && !adOe));

  a_r8_ack_at_rd_rise: assert property (@(posedge clk) disable iff (rst || !armed)
    $rose(rdN) |-> ack);

  a_r8_ack_only_at_rise: assert property (@(posedge clk) disable iff (rst || !armed)
    ack |-> $rose(rdN));

  a_r10_clk_toggle: assert property (@(posedge clk) disable iff (rst || !armed)
    clkOut != $past(clkOut));
endmodule

bind extbus_seq extbus_seq_chk chk (.*);

// File: tb/extbus_seq_test.sv
`timescale 1ns/1ps
module extbus_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [15:0] addrIn = '0;
  logic [2:0]  waitIn = '0;
  logic        forceWait = 1'b0;
  logic [15:0] busDataIn = '0;
  logic        ack, clkOut, ale, rdN, adOe;
  logic [15:0] rdData, adOut;

  extbus_seq uut (
    .clk(clk), .rst(rst), .req(req), .addrIn(addrIn), .waitIn(waitIn),
    .forceWait(forceWait), .busDataIn(busDataIn), .ack(ack), .rdData(rdData),
    .clkOut(clkOut), .ale(ale), .rdN(rdN), .adOut(adOut), .adOe(adOe)
  );

  always #2.5 clk = !clk;

  int checks = 0;
  int errors = 0;
  int tick = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at tick %0d", tag, act, expv, tick);
    end
  endtask

  // Behavioural reference: queue of expected per-tick outputs
  typedef struct {
    bit          ale;
    bit          oe;
    bit          rdn;
    bit          last;
    logic [15:0] addr;
  } tickExp_t;
  tickExp_t q[$];
  bit          expAck = 0;
  logic [15:0] expData = '0;
  int          sinceRst = 0;

  always @(posedge clk) begin
    bit wasLast;
    tick++;
    wasLast = 0;
    if (rst) begin
      q.delete();
      expAck = 0;
      sinceRst = 0;
    end else begin
      sinceRst++;
      if (q.size() > 0) begin
        wasLast = q[0].last;
        void'(q.pop_front());
      end
      expAck = wasLast;
      if (wasLast) expData = busDataIn;
      if (q.size() == 0 && req) begin
        int w;
        int len;
        tickExp_t e;
        w = int'(waitIn) + int'(forceWait);
        len = 4 + 2 * w;
        for (int k = 0; k < len; k++) begin
          e.ale  = (k == 0);
          e.oe   = (k < 2);
          e.rdn  = !(k >= 2);
          e.last = (k == len - 1);
          e.addr = addrIn;
          q.push_back(e);
        end
      end
    end
  end

  // Per-tick comparison, mid-tick
  logic prevClk = 1'b0;
  always @(negedge clk) begin
    bit eAle, eOe, eRdn;
    if (!rst && !finished) begin
      eAle = (q.size() > 0) ? q[0].ale : 1'b0;
      eOe  = (q.size() > 0) ? q[0].oe  : 1'b0;
      eRdn = (q.size() > 0) ? q[0].rdn : 1'b1;
      chk(ale == eAle, "R3 ale", ale, eAle);
      chk(adOe == eOe, "R4 adOe", adOe, eOe);
      if (eOe) chk(adOut == q[0].addr, "R4 adOut", adOut, q[0].addr);
      chk(rdN == eRdn, "R5 rdN", rdN, eRdn);
      chk(ack == expAck, "R8 ack", ack, expAck);
      if (expAck) chk(rdData == expData, "R8 rdData", rdData, expData);
      if (sinceRst > 1) chk(clkOut != prevClk, "R10 clkOut toggle", clkOut, !prevClk);
    end
    prevClk = clkOut;
  end

  task automatic waitAck(output bit got);
    got = 0;
    for (int i = 0; i < 40 && !got; i++) begin
      @(negedge clk);
      if (ack) got = 1;
    end
  endtask

  // One isolated read; waitIn and forceWait are flipped mid-cycle (ignored per R6)
  task automatic doRead(input logic [15:0] a, input logic [2:0] w, input bit f,
                        input logic [15:0] d, input string tag);
    int t0;
    int expLen;
    bit got;
    @(negedge clk);
    req = 1; addrIn = a; waitIn = w; forceWait = f; busDataIn = d;
    @(negedge clk);
    chk(ale == 1'b1, "R3 start", ale, 1);
    t0 = tick;
    req = 0; waitIn = ~w; forceWait = !f; addrIn = ~a;
    waitAck(got);
    expLen = 4 + 2 * (int'(w) + int'(f));
    chk(got, tag, got, 1);
    chk(tick - t0 == expLen, tag, tick - t0, expLen);
    chk(rdData == d, "R8 data", rdData, d);
    forceWait = 0;
    waitIn = 0;
  endtask

  initial begin
    bit got;
    int t1;
    int t2;
    repeat (3) @(negedge clk);
    chk(ale == 0 && rdN == 1 && adOe == 0 && ack == 0, "R1 reset state", {ale, rdN, adOe, ack}, 4'b0100);
    chk(clkOut == 0, "R10 clkOut in reset", clkOut, 0);
    rst = 0;
    repeat (6) @(negedge clk);
    chk(ale == 0 && rdN == 1 && adOe == 0, "R2 idle", {ale, rdN, adOe}, 3'b010);

    doRead(16'h1234, 3'd0, 0, 16'hA5A5, "R6 zero-wait length");
    doRead(16'h0F0F, 3'd2, 0, 16'h5A5A, "R6 two-wait length");
    doRead(16'hBEEF, 3'd7, 0, 16'h0001, "R6 seven-wait length");
    doRead(16'h4321, 3'd0, 1, 16'hFFFF, "R7 forced wait length");
    doRead(16'hCAFE, 3'd7, 1, 16'h8000, "R7 max total length");
    doRead(16'h0000, 3'd3, 1, 16'h1357, "R7 forced plus three");

    // Back-to-back: req held, no idle tick between cycles (R9)
    @(negedge clk);
    req = 1; addrIn = 16'h7001; waitIn = 3'd1; forceWait = 0; busDataIn = 16'h2468;
    @(negedge clk);
    t1 = tick;
    addrIn = 16'h7002;
    got = 0;
    for (int i = 0; i < 20 && !got; i++) begin
      @(negedge clk);
      if (ale) got = 1;
    end
    t2 = tick;
    chk(got, "R9 second ale", got, 1);
    chk(t2 - t1 == 6, "R9 gapless spacing", t2 - t1, 6);
    chk(ack == 1, "R9 ack with next ale", ack, 1);
    waitIn = 3'd0; forceWait = 1;
    got = 0;
    for (int i = 0; i < 20 && !got; i++) begin
      @(negedge clk);
      if (ale) got = 1;
    end
    chk(tick - t2 == 6, "R9 third spacing", tick - t2, 6);
    req = 0;
    t1 = tick;
    waitAck(got);
    chk(tick - t1 == 6, "R7 forced wait back-to-back", tick - t1, 6);

    // Reset in mid-cycle returns to idle (R1)
    @(negedge clk);
    req = 1; waitIn = 3'd5;
    repeat (3) @(negedge clk);
    req = 0; rst = 1;
    @(negedge clk);
    chk(ale == 0 && rdN == 1 && adOe == 0 && ack == 0, "R1 mid-cycle reset", {ale, rdN, adOe, ack}, 4'b0100);
    rst = 0;
    repeat (5) @(negedge clk);
    chk(ale == 0 && rdN == 1 && adOe == 0, "R2 idle after reset", {ale, rdN, adOe}, 3'b010);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule